// File: doc/BRIEF.md
# Multi-Mode Timer with PWM and Input Capture

This block is a bus-programmable timer with two down-counters fed from a shared clock prescaler. It has two reload registers, a control register and an interrupt register that holds four enable and pending pairs. One control field picks the operating mode:

- a PWM generator alongside a free-running system timer;
- an input-capture unit alongside a system timer;
- two independent timers.

A single pin acts as the PWM output or as the capture input, depending on the mode. Because the block has no pad, the pin appears as an input, an output and an output-enable. Software programs the block through a single-cycle write port and a combinational read port.

A five-state machine follows the mode and the pin phase. Its states are `ST_OFF`, `ST_PWM_HI`, `ST_PWM_LO`, `ST_CAPT` and `ST_DUAL`.

- Any state goes to `ST_OFF` when the block is disabled or the mode field holds the reserved code.
- With the PWM mode selected, `ST_OFF`, `ST_CAPT` and `ST_DUAL` enter `ST_PWM_HI`.
- `ST_PWM_HI` goes to `ST_PWM_LO` on a counter 1 underflow, and `ST_PWM_LO` goes back to `ST_PWM_HI` on the next underflow.
- Selecting the capture mode leads to `ST_CAPT`, and selecting the dual mode leads to `ST_DUAL`.

Pending flags are sticky. They can be cleared only through a dedicated clear address.

Top module: `mm_timer`

## Requirements
- R1: After reset, the control register (address 4) and the interrupt register (address 5) read 0, and `irq`, `pin_oe` and `pin_out` are low.
- R2: The registers sit at these addresses: counter 1 at 0, counter 2 at 1, reload A at 2, reload B at 3, control at 4, interrupt at 5 and interrupt-clear at 6. Counter and reload values read back zero-extended to 16 bits, and address 6 reads 0. The reload registers are not reset.
- R3: While the enable bit (control bit 5) is 0, the prescaler is cleared, all pending bits read 0, writes to the counters, the reload registers and the pending bits are ignored, the counters hold their values and `pin_oe` is low. The interrupt enables stay writable.
- R4: The counters step down once every 2^PRESC_W clocks.
- R5: In mode 00 (control bits 1:0), an underflow in the high phase drives the output low and reloads counter 1 from B. An underflow in the low phase drives it high and reloads from A. The output therefore stays high for (A+1)·2^PRESC_W clocks and low for (B+1)·2^PRESC_W clocks.
- R6: The output bit (control bit 4) drives `pin_out`. A software write to it takes precedence over a hardware update in the same cycle.
- R7: In mode 01, a qualifying pin edge copies counter 1 into reload A, presets counter 1 to all ones and sets pending A (interrupt bit 0). The pin is not driven in this mode.
- R8: The polarity bit (control bit 2) selects the qualifying edge: 1 selects rising edges and 0 selects falling edges. An edge of the other direction has no effect.
- R9: With the pin-enable bit (control bit 3) at 0, pin edges have no effect and the pin is not driven.
- R10: In mode 10, counter 1 reloads from A and the output toggles on every underflow, giving a half-period of (A+1)·2^PRESC_W clocks.
- R11: Counter 2 reloads from B and sets pending C (bit 2) on underflow in every running mode. An underflow of counter 1 sets pending B (bit 1).
- R12: Writing 1s to interrupt bits 3:0 sets those pending bits, and 0s there are ignored. Pending bits clear only when 1s are written to the same bits at address 6. Interrupt bits 7:4 are the enables for A to D.
- R13: `irq` is high exactly when some pending bit is set together with its enable.
- R14: Mode 11 is reserved, and in it both counters hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| pin_in | input | 1 | Level at the timer pin |
| pin_out | output | 1 | Value driven onto the timer pin |
| pin_oe | output | 1 | Drive enable for the timer pin |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with CNT_W = 8 and PRESC_W = 2, so a counter steps every four clocks. With these values a full PWM high-and-low cycle, a dual-mode toggle and counter 2 underflows each fit in a few dozen cycles. The bench can also predict the exact clock of each underflow. That lets it land a software write to the output bit on the same edge as a hardware update, and lets it check that all-ones preset values sit within a tick or two of 8'hFF.

// File: rtl/mmt_pkg.sv
package mmt_pkg;

    typedef enum logic [1:0] {
        MODE_PWM  = 2'b00,
        MODE_CAPT = 2'b01,
        MODE_DUAL = 2'b10,
        MODE_RSVD = 2'b11
    } mode_e;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_PWM_HI,
        ST_PWM_LO,
        ST_CAPT,
        ST_DUAL
    } state_e;

    localparam logic [2:0] ADR_CNT1 = 3'd0;
    localparam logic [2:0] ADR_CNT2 = 3'd1;
    localparam logic [2:0] ADR_RLDA = 3'd2;
    localparam logic [2:0] ADR_RLDB = 3'd3;
    localparam logic [2:0] ADR_CTRL = 3'd4;
    localparam logic [2:0] ADR_ICTL = 3'd5;
    localparam logic [2:0] ADR_ICLR = 3'd6;

    localparam int NUM_IRQ = 4;

endpackage

// File: rtl/mmt_prescaler.sv
module mmt_prescaler #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    output logic         tick,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            count <= '0;
        end else begin
            count <= count + 1'b1;
        end
    end

    assign tick = run && (count == '1);
endmodule

// File: rtl/mmt_edge_det.sv
module mmt_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic rising_sel,
    input  logic din,
    output logic hit
);
    logic sync_q;
    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= din;
            prev_q <= sync_q;
        end
    end

    assign hit = enable && (rising_sel ? (sync_q && !prev_q) : (!sync_q && prev_q));
endmodule

// File: rtl/mmt_down_counter.sv
module mmt_down_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wr_val,
    input  logic         preset,
    input  logic         tick,
    input  logic [W-1:0] reload_val,
    output logic [W-1:0] value,
    output logic         uflow
);
    assign uflow = tick && (value == '0) && !wr && !preset;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (wr) begin
            value <= wr_val;
        end else if (preset) begin
            value <= '1;
        end else if (tick) begin
            value <= (value == '0) ? reload_val : value - 1'b1;
        end
    end
endmodule

// File: rtl/mm_timer.sv
module mm_timer
    import mmt_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int PRESC_W = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        pin_in,
    output logic        pin_out,
    output logic        pin_oe,
    output logic        irq
);
    localparam int DW = 16;

    // control and interrupt registers
    mode_e              mode_q;
    logic               edge_rise_q;
    logic               pin_en_q;
    logic               out_q;
    logic               ten_q;
    logic [NUM_IRQ-1:0] ien_q;
    logic [NUM_IRQ-1:0] pend_q;
    logic [NUM_IRQ-1:0] pend_d;
    logic [CNT_W-1:0]   rld_a_q;
    logic [CNT_W-1:0]   rld_b_q;

    state_e state_q;
    state_e state_d;

    logic               presc_tick;
    logic [PRESC_W-1:0] presc_cnt;
    logic               cnt_tick;
    logic               capture_evt;
    logic [CNT_W-1:0]   cnt1_val;
    logic [CNT_W-1:0]   cnt2_val;
    logic               u1;
    logic               u2;
    logic [CNT_W-1:0]   rld1_sel;
    logic               hw_out_upd;
    logic               hw_out_val;

    // write strobes (data-path writes gated by the enable)
    logic wr_ctrl, wr_ictl, wr_iclr, wr_cnt1, wr_cnt2, wr_rlda, wr_rldb;
    assign wr_ctrl = bus_wr && (bus_addr == ADR_CTRL);
    assign wr_ictl = bus_wr && (bus_addr == ADR_ICTL);
    assign wr_iclr = bus_wr && (bus_addr == ADR_ICLR);
    assign wr_cnt1 = bus_wr && (bus_addr == ADR_CNT1) && ten_q;
    assign wr_cnt2 = bus_wr && (bus_addr == ADR_CNT2) && ten_q;
    assign wr_rlda = bus_wr && (bus_addr == ADR_RLDA) && ten_q;
    assign wr_rldb = bus_wr && (bus_addr == ADR_RLDB) && ten_q;

    mmt_prescaler #(.W(PRESC_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ten_q),
        .tick  (presc_tick),
        .count (presc_cnt)
    );

    assign cnt_tick = presc_tick && (state_q != ST_OFF);

    mmt_edge_det u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (ten_q && pin_en_q && (state_q == ST_CAPT)),
        .rising_sel (edge_rise_q),
        .din        (pin_in),
        .hit        (capture_evt)
    );

    mmt_down_counter #(.W(CNT_W)) u_cnt1 (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (wr_cnt1),
        .wr_val     (bus_wdata[CNT_W-1:0]),
        .preset     (capture_evt),
        .tick       (cnt_tick),
        .reload_val (rld1_sel),
        .value      (cnt1_val),
        .uflow      (u1)
    );

    mmt_down_counter #(.W(CNT_W)) u_cnt2 (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (wr_cnt2),
        .wr_val     (bus_wdata[CNT_W-1:0]),
        .preset     (1'b0),
        .tick       (cnt_tick),
        .reload_val (rld_b_q),
        .value      (cnt2_val),
        .uflow      (u2)
    );

    // control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q      <= MODE_PWM;
            edge_rise_q <= 1'b0;
            pin_en_q    <= 1'b0;
            ten_q       <= 1'b0;
        end else if (wr_ctrl) begin
            mode_q      <= mode_e'(bus_wdata[1:0]);
            edge_rise_q <= bus_wdata[2];
            pin_en_q    <= bus_wdata[3];
            ten_q       <= bus_wdata[5];
        end
    end

    // output bit: software write has precedence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else if (wr_ctrl) begin
            out_q <= bus_wdata[4];
        end else if (hw_out_upd) begin
            out_q <= hw_out_val;
        end
    end

    // reload registers (no reset)
    always_ff @(posedge clk) begin
        if (wr_rlda) begin
            rld_a_q <= bus_wdata[CNT_W-1:0];
        end else if (capture_evt) begin
            rld_a_q <= cnt1_val;
        end
        if (wr_rldb) begin
            rld_b_q <= bus_wdata[CNT_W-1:0];
        end
    end

    // interrupt enables and pending flags
    always_comb begin
        logic [NUM_IRQ-1:0] hw_set;
        logic [NUM_IRQ-1:0] sw_set;
        logic [NUM_IRQ-1:0] clr;
        hw_set = {1'b0, u2, u1, capture_evt};
        sw_set = (wr_ictl && ten_q) ? bus_wdata[NUM_IRQ-1:0] : '0;
        clr    = wr_iclr ? bus_wdata[NUM_IRQ-1:0] : '0;
        pend_d = ten_q ? ((pend_q & ~clr) | hw_set | sw_set) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q  <= '0;
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
            if (wr_ictl) begin
                ien_q <= bus_wdata[2*NUM_IRQ-1:NUM_IRQ];
            end
        end
    end

    assign irq = |(pend_q & ien_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = ST_OFF;
        if (ten_q) begin
            unique case (mode_q)
                MODE_PWM: begin
                    if (state_q == ST_PWM_HI) begin
                        state_d = u1 ? ST_PWM_LO : ST_PWM_HI;
                    end else if (state_q == ST_PWM_LO) begin
                        state_d = u1 ? ST_PWM_HI : ST_PWM_LO;
                    end else begin
                        state_d = ST_PWM_HI;
                    end
                end
                MODE_CAPT: state_d = ST_CAPT;
                MODE_DUAL: state_d = ST_DUAL;
                MODE_RSVD: state_d = ST_OFF;
            endcase
        end
    end

    // state outputs
    always_comb begin
        rld1_sel   = rld_a_q;
        hw_out_upd = 1'b0;
        hw_out_val = out_q;
        pin_oe     = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                rld1_sel = rld_a_q;
            end
            ST_PWM_HI: begin
                rld1_sel   = rld_b_q;
                hw_out_upd = u1;
                hw_out_val = 1'b0;
                pin_oe     = pin_en_q && ten_q;
            end
            ST_PWM_LO: begin
                rld1_sel   = rld_a_q;
                hw_out_upd = u1;
                hw_out_val = 1'b1;
                pin_oe     = pin_en_q && ten_q;
            end
            ST_CAPT: begin
                rld1_sel = '1;
            end
            ST_DUAL: begin
                rld1_sel   = rld_a_q;
                hw_out_upd = u1;
                hw_out_val = !out_q;
                pin_oe     = pin_en_q && ten_q;
            end
        endcase
    end

    assign pin_out = out_q;

    // read mux
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADR_CNT1: bus_rdata = DW'(cnt1_val);
            ADR_CNT2: bus_rdata = DW'(cnt2_val);
            ADR_RLDA: bus_rdata = DW'(rld_a_q);
            ADR_RLDB: bus_rdata = DW'(rld_b_q);
            ADR_CTRL: bus_rdata = DW'({ten_q, out_q, pin_en_q, edge_rise_q, mode_q});
            ADR_ICTL: bus_rdata = DW'({ien_q, pend_q});
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mm_timer_chk.sv
module mm_timer_chk
    import mmt_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int PRESC_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ten_q,
    input logic [3:0]         pend_q,
    input logic [PRESC_W-1:0] presc_cnt,
    input logic               capture_evt,
    input logic [CNT_W-1:0]   cnt1_val,
    input logic [CNT_W-1:0]   rld1_sel,
    input logic               u1,
    input logic               pin_oe,
    input logic               out_q,
    input logic               bus_wr,
    input logic [2:0]         bus_addr,
    input logic               wr_out_bit
);
    // R3
    dis_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ten_q |=> (pend_q == '0));

    // R3
    dis_presc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ten_q |=> (presc_cnt == '0));

    // R7
    preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture_evt && !(bus_wr && bus_addr == ADR_CNT1) |=> (cnt1_val == '1));

    // R7
    capt_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture_evt |-> !pin_oe);

    // R12
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ten_q && !(bus_wr && bus_addr == ADR_ICLR) |=> (($past(pend_q) & ~pend_q) == '0));

    // R5
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        u1 |=> (cnt1_val == $past(rld1_sel)));

    // R6
    out_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == ADR_CTRL |=> (out_q == $past(wr_out_bit)));
endmodule

bind mm_timer mm_timer_chk #(.CNT_W(CNT_W), .PRESC_W(PRESC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ten_q       (ten_q),
    .pend_q      (pend_q),
    .presc_cnt   (presc_cnt),
    .capture_evt (capture_evt),
    .cnt1_val    (cnt1_val),
    .rld1_sel    (rld1_sel),
    .u1          (u1),
    .pin_oe      (pin_oe),
    .out_q       (out_q),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .wr_out_bit  (bus_wdata[4])
);

// File: tb/mm_timer_test.sv
`timescale 1ns/1ps
module mm_timer_test;
    localparam int CNT_W   = 8;
    localparam int PRESC_W = 2;
    localparam int TICK    = 1 << PRESC_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        pin_in = 1'b0;
    logic        pin_out;
    logic        pin_oe;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mm_timer #(.CNT_W(CNT_W), .PRESC_W(PRESC_W)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // {waddr, wdata, raddr, expected read, expected irq}
    localparam int NV = 14;
    localparam logic [38:0] VEC [NV] = '{
        {3'd4, 16'h0000, 3'd4, 16'h0000, 1'b0},
        {3'd0, 16'h0055, 3'd0, 16'h0000, 1'b0},
        {3'd5, 16'h000F, 3'd5, 16'h0000, 1'b0},
        {3'd4, 16'h0023, 3'd4, 16'h0023, 1'b0},
        {3'd0, 16'h0055, 3'd0, 16'h0055, 1'b0},
        {3'd1, 16'h00AA, 3'd1, 16'h00AA, 1'b0},
        {3'd2, 16'h0012, 3'd2, 16'h0012, 1'b0},
        {3'd3, 16'h0034, 3'd3, 16'h0034, 1'b0},
        {3'd5, 16'h0005, 3'd5, 16'h0005, 1'b0},
        {3'd5, 16'h0000, 3'd5, 16'h0000, 1'b0},
        {3'd6, 16'h0001, 3'd5, 16'h0004, 1'b0},
        {3'd5, 16'h00F0, 3'd5, 16'h00F4, 1'b1},
        {3'd4, 16'h0003, 3'd5, 16'h00F0, 1'b0},
        {3'd4, 16'h0023, 3'd0, 16'h0055, 1'b0}
    };
    // row 10 expects 0x0005 unchanged: zero writes to pending bits are ignored
    localparam logic [15:0] ROW10_EXP = 16'h0005;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_rng(input string req, input logic [15:0] act,
                             input logic [15:0] lo, input logic [15:0] hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h..%h", req, act, lo, hi);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic meas(input logic lvl, output int n);
        n = 0;
        while (pin_out == lvl && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wait_lvl(input logic lvl);
        int k = 0;
        while (pin_out != lvl && k < 1000) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] d;
        logic [15:0] c1;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd4, d); check("R1 ctrl", d, 16'h0);
        rd(3'd5, d); check("R1 ictl", d, 16'h0);
        check("R1 irq", {15'd0, irq}, 16'h0);
        check("R1 pin_oe", {15'd0, pin_oe}, 16'h0);
        check("R1 pin_out", {15'd0, pin_out}, 16'h0);

        // table: R2 map, R3 disable, R12 pending, R13 irq, R14 reserved hold
        for (int i = 0; i < NV; i++) begin
            logic [2:0]  wa;
            logic [15:0] wd;
            logic [2:0]  ra;
            logic [15:0] ex;
            logic        ei;
            {wa, wd, ra, ex, ei} = VEC[i];
            if (i == 9) ex = ROW10_EXP;
            wr(wa, wd);
            repeat (2) @(negedge clk);
            rd(ra, d);
            check($sformatf("R2/R3/R12/R13/R14 row %0d read", i), d, ex);
            check($sformatf("R13 row %0d irq", i), {15'd0, irq}, {15'd0, ei});
        end

        // R14 counters hold in reserved mode over many cycles
        rd(3'd0, c1);
        repeat (20) @(negedge clk);
        rd(3'd0, d); check("R14 cnt1 held", d, c1);

        // R5 PWM timing, R4 prescale, R11 pending B
        wr(3'd2, 16'd2);
        wr(3'd3, 16'd4);
        wr(3'd0, 16'd0);
        wr(3'd6, 16'h000F);
        wr(3'd4, 16'h0028);
        @(negedge clk);
        check("R5 pin_oe", {15'd0, pin_oe}, 16'h1);
        wait_lvl(1'b1);
        meas(1'b1, n); check("R5 R4 high time", 16'(n), 16'(3 * TICK));
        meas(1'b0, n); check("R5 R4 low time", 16'(n), 16'(5 * TICK));
        rd(3'd5, d); check("R11 pending B", d & 16'h2, 16'h2);

        // R6: software write lands on the same edge as the high-phase underflow
        repeat (3 * TICK - 2) @(negedge clk);
        wr(3'd4, 16'h0038);
        check("R6 sw wins", {15'd0, pin_out}, 16'h1);
        repeat (6) @(negedge clk);
        check("R6 stays high", {15'd0, pin_out}, 16'h1);
        rd(3'd4, d); check("R6 ctrl out bit", d & 16'h10, 16'h10);

        // R7 capture, rising polarity
        wr(3'd4, 16'h0023);
        wr(3'd6, 16'h000F);
        wr(3'd0, 16'h0080);
        wr(3'd4, 16'h002D);
        repeat (2) @(negedge clk);
        pin_in = 1'b1;
        repeat (4) @(negedge clk);
        rd(3'd5, d); check("R7 pending A", d & 16'h1, 16'h1);
        rd(3'd0, d); check_rng("R7 preset", d, 16'h00FD, 16'h00FF);
        rd(3'd2, d); check_rng("R7 captured", d, 16'h007A, 16'h0080);
        check("R7 pin undriven", {15'd0, pin_oe}, 16'h0);

        // R8 falling edge ignored with rising polarity
        wr(3'd6, 16'h0001);
        pin_in = 1'b0;
        repeat (6) @(negedge clk);
        rd(3'd5, d); check("R8 falling ignored", d & 16'h1, 16'h0);

        // R8 falling polarity
        wr(3'd4, 16'h0029);
        repeat (2) @(negedge clk);
        pin_in = 1'b1;
        repeat (6) @(negedge clk);
        rd(3'd5, d); check("R8 rising ignored", d & 16'h1, 16'h0);
        pin_in = 1'b0;
        repeat (6) @(negedge clk);
        rd(3'd5, d); check("R8 falling taken", d & 16'h1, 16'h1);

        // R9 pin disabled
        wr(3'd4, 16'h0025);
        wr(3'd6, 16'h0001);
        repeat (2) @(negedge clk);
        pin_in = 1'b1;
        repeat (6) @(negedge clk);
        rd(3'd5, d); check("R9 edge ignored", d & 16'h1, 16'h0);
        check("R9 pin undriven", {15'd0, pin_oe}, 16'h0);

        // R10 dual mode toggling, R11 pending C
        wr(3'd4, 16'h0023);
        wr(3'd6, 16'h000F);
        wr(3'd2, 16'd1);
        wr(3'd0, 16'd0);
        wr(3'd1, 16'd3);
        wr(3'd4, 16'h002A);
        @(negedge clk);
        check("R10 pin_oe", {15'd0, pin_oe}, 16'h1);
        wait_lvl(!pin_out);
        meas(pin_out, n); check("R10 half period", 16'(n), 16'(2 * TICK));
        repeat (40) @(negedge clk);
        rd(3'd5, d); check("R11 pending C", d & 16'h4, 16'h4);

        // R3 disable drops pin drive and pending
        wr(3'd4, 16'h000A);
        @(negedge clk);
        check("R3 pin_oe off", {15'd0, pin_oe}, 16'h0);
        rd(3'd5, d); check("R3 pending cleared", d & 16'hF, 16'h0);

        finish_run();
    end
endmodule